// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running phase of the chroma subcarrier used for composite and separate luma/chroma video, advancing once per pixel clock (27 MHz in the target system). A 32-bit accumulator adds a frequency tuning word on every clock and wraps modulo 2^32. The word equals the ratio of subcarrier periods per line to pixel clocks per line, scaled by 2^32 and rounded to the nearest integer. For 525-line video this is 0x21F07C1F, from 227.5 periods over 1716 clocks. For 625-line video it is 0x2A098ACB.

The tuning word is loaded one byte at a time through a byte-wide write port. It occupies four consecutive addresses starting at `BASE_ADDR`, with offset 0 the least significant byte. Bytes 0 to 2 land in a shadow register. The byte at offset 3 completes the word, and the whole 32-bit value becomes active at once. The order of the writes is enforced. A phase-clear input realigns the accumulator to zero at any chosen line or field. The full phase and its top `LUT_BITS` bits, which index a sine table, are the outputs.

Top module: `fsc_dds`

## Requirements
- R1: While `rst_ni` is low, `phase_o` reads 0. After reset the active tuning word is 0x21F07C1F, and the shadow bytes 0..2 hold 0x1F, 0x7C and 0xF0.
- R2: On every rising clock edge with `phase_clr_i` low, `phase_o` becomes its previous value plus the active tuning word, modulo 2^32.
- R3: `lut_idx_o` always equals bits [31:32-LUT_BITS] of `phase_o`.
- R4: A write to offset 0, 1 or 2 (address `BASE_ADDR`+offset) changes only the shadow byte and leaves the active tuning word unchanged.
- R5: A write to offset 3, when it is the next expected offset, sets the active word to {data, shadow byte 2, shadow byte 1, shadow byte 0}. The increment at that same edge still uses the old word. The new word is used from the next edge onward.
- R6: Offsets must be written in the order 0,1,2,3. A write to offset 1, 2 or 3 that is not the next expected offset is ignored: no shadow byte, no active word and no expected position changes.
- R7: A write to offset 0 is always accepted and restarts the sequence, so that offset 1 is expected next. After a commit, offset 0 is expected.
- R8: With `phase_clr_i` high at a rising edge, `phase_o` becomes 0 at that edge, taking priority over the increment. A write at the same edge is still handled.
- R9: Writes to addresses outside `BASE_ADDR`..`BASE_ADDR`+3 change neither the shadow bytes, the active word nor the expected position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| phase_clr_i | input | 1 | Synchronous phase clear |
| phase_o | output | PHASE_W | Accumulator phase |
| lut_idx_o | output | LUT_BITS | Top phase bits for the sine table |

## Verification
The bench loads the 625-line word and watches the exact edge where the increment switches words. A design that commits early, or that adds the new word at the commit edge itself, drifts off the reference phase by one step. Out-of-order writes, a mid-sequence restart at offset 0, a stray offset-3 write right after a commit, and writes just outside the window are each followed by a full sequence. A design that stores or commits them shows a wrong byte in the active word. Phase clears are issued alone and on a commit edge, and runs past several wraps expose a design that saturates or keeps extra high bits.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int unsigned LANE_IDX_W = 4;
  localparam logic [31:0] FSC_WORD_525 = 32'h21F0_7C1F;
  localparam logic [31:0] FSC_WORD_625 = 32'h2A09_8ACB;

  typedef struct packed {
    logic                  valid;
    logic [LANE_IDX_W-1:0] lane;
  } lane_sel_t;
endpackage

// File: rtl/fsc_wr_decode.sv
module fsc_wr_decode
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 8'h40,
  parameter int unsigned NUM_LANES = 4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output lane_sel_t         sel_o
);
  localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LANES = ADDR_W'(NUM_LANES);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off         = wr_addr_i - BASE;
    sel_o.valid = wr_en_i && (wr_addr_i >= BASE) && (off < LANES);
    sel_o.lane  = LANE_IDX_W'(off);
  end
endmodule

// File: rtl/fsc_shadow.sv
module fsc_shadow
  import fsc_pkg::*;
#(
  parameter int unsigned PHASE_W    = 32,
  parameter logic [31:0] RESET_WORD = FSC_WORD_525
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  lane_sel_t            sel_i,
  input  logic [7:0]           data_i,
  output logic [PHASE_W-9:0]   shadow_o,
  output logic [PHASE_W-1:0]   active_o,
  output logic [LANE_IDX_W-1:0] seq_o
);
  localparam int unsigned NUM_LANES = PHASE_W / 8;
  localparam logic [LANE_IDX_W-1:0] LAST = LANE_IDX_W'(NUM_LANES - 1);
  localparam logic [PHASE_W-1:0] RST_W = PHASE_W'(RESET_WORD);

  logic [LANE_IDX_W-1:0] seq_q;
  logic [PHASE_W-1:0]    active_q;
  logic [PHASE_W-1:0]    commit_word;
  logic                  accept;
  logic                  commit;

  // offset 0 always restarts; others only in sequence
  assign accept = sel_i.valid && (sel_i.lane == '0 || sel_i.lane == seq_q);
  assign commit = accept && (sel_i.lane == LAST);

  for (genvar g = 0; g < NUM_LANES - 1; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              byte_q <= RST_W[g*8 +: 8];
      else if (accept && sel_i.lane == LANE_IDX_W'(g)) byte_q <= data_i;
    end
    assign shadow_o[g*8 +: 8]    = byte_q;
    assign commit_word[g*8 +: 8] = byte_q;
  end
  assign commit_word[PHASE_W-1 -: 8] = data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q    <= '0;
      active_q <= RST_W;
    end else if (accept) begin
      seq_q <= commit ? '0 : sel_i.lane + 1'b1;
      if (commit) active_q <= commit_word;
    end
  end

  assign active_o = active_q;
  assign seq_o    = seq_q;
endmodule

// File: rtl/fsc_accum.sv
module fsc_accum #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [PHASE_W-1:0] step_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else            phase_q <= phase_q + step_i;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/fsc_dds.sv
module fsc_dds
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BASE_ADDR  = 8'h40,
  parameter int unsigned PHASE_W    = 32,
  parameter int unsigned LUT_BITS   = 10,
  parameter logic [31:0] RESET_WORD = FSC_WORD_525
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic                phase_clr_i,
  output logic [PHASE_W-1:0]  phase_o,
  output logic [LUT_BITS-1:0] lut_idx_o
);
  localparam int unsigned NUM_LANES = PHASE_W / 8;

  lane_sel_t             sel;
  logic [PHASE_W-9:0]    shadow_word;
  logic [PHASE_W-1:0]    active_word;
  logic [LANE_IDX_W-1:0] seq_pos;

  fsc_wr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_LANES(NUM_LANES)
  ) u_dec (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .sel_o(sel)
  );

  fsc_shadow #(
    .PHASE_W(PHASE_W), .RESET_WORD(RESET_WORD)
  ) u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .data_i(wr_data_i),
    .shadow_o(shadow_word), .active_o(active_word), .seq_o(seq_pos)
  );

  fsc_accum #(
    .PHASE_W(PHASE_W)
  ) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(phase_clr_i),
    .step_i(active_word), .phase_o(phase_o)
  );

  assign lut_idx_o = phase_o[PHASE_W-1 -: LUT_BITS];
endmodule

// File: rtl/fsc_dds_chk.sv
module fsc_dds_chk
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 8'h40,
  parameter int unsigned PHASE_W   = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic [7:0]            wr_data_i,
  input logic                  phase_clr_i,
  input logic [PHASE_W-1:0]    phase_o,
  input logic [PHASE_W-9:0]    shadow_word,
  input logic [PHASE_W-1:0]    active_word,
  input logic [LANE_IDX_W-1:0] seq_pos
);
  localparam int NL = PHASE_W / 8;
  int off;
  logic in_win, wr_first, wr_low, wr_last_ok, wr_ooo, wr_out;

  always_comb begin
    off        = int'(wr_addr_i) - int'(BASE_ADDR);
    in_win     = off >= 0 && off < NL;
    wr_first   = wr_en_i && in_win && off == 0;
    wr_low     = wr_en_i && in_win && off < NL - 1;
    wr_last_ok = wr_en_i && in_win && off == NL - 1 && int'(seq_pos) == NL - 1;
    wr_ooo     = wr_en_i && in_win && off != 0 && off != int'(seq_pos);
    wr_out     = wr_en_i && !in_win;
  end

  always_comb if (!rst_ni) AST_RESET_PHASE: assert (phase_o == '0); // R1

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_clr_i |=> phase_o == $past(phase_o) + $past(active_word)); // R2
  AST_NO_EARLY_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_low |=> $stable(active_word)); // R4
  AST_COMMIT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_last_ok |=> active_word == {$past(wr_data_i), $past(shadow_word)}); // R5
  AST_OUT_OF_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ooo |=> $stable(shadow_word) && $stable(active_word) && $stable(seq_pos)); // R6
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_first |=> seq_pos == LANE_IDX_W'(1)); // R7
  AST_PHASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_clr_i |=> phase_o == '0); // R8
  AST_OUTSIDE_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out |=> $stable(shadow_word) && $stable(active_word) && $stable(seq_pos)); // R9
endmodule

bind fsc_dds fsc_dds_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .PHASE_W(PHASE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .phase_clr_i(phase_clr_i), .phase_o(phase_o),
  .shadow_word(shadow_word), .active_word(active_word), .seq_pos(seq_pos)
);

// File: tb/sim_fsc_dds.sv
`timescale 1ns/1ps
module sim_fsc_dds;
  localparam int BASE = 8'h40;
  localparam int LUTB = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0, clr = 0;
  logic [7:0]  wr_addr = 0, wr_data = 0;
  logic [31:0] phase;
  logic [LUTB-1:0] lut;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  logic [7:0]  m_sh[3];
  logic [31:0] m_act, m_phase;
  int          m_next;

  fsc_dds #(.ADDR_W(8), .BASE_ADDR(BASE), .PHASE_W(32), .LUT_BITS(LUTB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .phase_clr_i(clr), .phase_o(phase), .lut_idx_o(lut)
  );

  always #2 clk = ~clk;

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh[0] = 8'h1F; m_sh[1] = 8'h7C; m_sh[2] = 8'hF0;
      m_act = 32'h21F07C1F; m_phase = 0; m_next = 0;
    end else begin
      int idx;
      m_phase = clr ? 32'h0 : m_phase + m_act;
      idx = int'(wr_addr) - BASE;
      if (wr_en && idx >= 0 && idx < 4 && (idx == 0 || idx == m_next)) begin
        if (idx == 3) begin
          m_act = {wr_data, m_sh[2], m_sh[1], m_sh[0]};
          m_next = 0;
        end else begin
          m_sh[idx] = wr_data;
          m_next = idx + 1;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(cur_req, phase, m_phase);
    check("R3", 32'(lut), m_phase >> (32 - LUTB));
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int addr, logic [7:0] d);
    wr_en = 1; wr_addr = 8'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load(logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(BASE + i, w[i*8 +: 8]);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected<=50000", cycles);
      summary();
    end
  end

  initial begin
    idle(2);
    cur_req = "R1";
    check("R1", phase, 32'h0);
    rst_n = 1;
    idle(6);
    cur_req = "R2"; idle(40);            // several wraps
    cur_req = "R4";
    wr(BASE, 8'hCB); wr(BASE + 1, 8'h8A); wr(BASE + 2, 8'h09);
    idle(4);
    cur_req = "R5";
    wr(BASE + 3, 8'h2A);                 // 625-line word
    idle(8);
    cur_req = "R6";
    wr(BASE + 3, 8'h55);                 // stray offset 3 right after commit
    idle(3);
    wr(BASE, 8'h11); wr(BASE + 2, 8'h99); wr(BASE + 3, 8'h77);
    wr(BASE + 1, 8'h22); wr(BASE + 1, 8'hEE); wr(BASE + 2, 8'h33); wr(BASE + 3, 8'h04);
    idle(6);
    cur_req = "R7";
    wr(BASE, 8'hAA); wr(BASE + 1, 8'hBB); wr(BASE, 8'h1F); wr(BASE + 1, 8'h7C);
    wr(BASE + 2, 8'hF0); wr(BASE + 3, 8'h21);
    idle(6);
    cur_req = "R8";
    clr = 1; @(negedge clk); clr = 0; idle(3);
    wr(BASE, 8'h01); wr(BASE + 1, 8'h02); wr(BASE + 2, 8'h03);
    clr = 1; wr(BASE + 3, 8'h10); clr = 0;  // clear on commit edge
    idle(3);
    clr = 1; idle(2); clr = 0; idle(3);
    cur_req = "R9";
    wr(BASE, 8'hCB); wr(BASE + 1, 8'h8A); wr(BASE + 2, 8'h09);
    wr(BASE - 1, 8'hFF); wr(BASE + 4, 8'hFF); wr(BASE + 5, 8'h00);
    wr(BASE + 3, 8'h2A);
    idle(6);
    load(32'h21F07C1F);
    idle(6);
    summary();
  end
endmodule